// File: doc/BRIEF.md
# PWM Trip Fault Latch and Interrupt Gate

This block captures fault (trip) events for one PWM channel and reports them to software. Two kinds of trip input arrive: a one-shot source and a cycle-by-cycle source. Each has its own enable. Four digital-compare events, two per output, also arrive. Every event sets a sticky bit in a read-only flag register. Software clears a bit by writing a 1 to the matching position of a separate clear register.

Two trip conditions are driven to the downstream output-forcing logic. The one-shot condition follows the one-shot flag. The cycle-by-cycle condition is held in its own register. That register is released only at a time-base counter-zero strobe, and only when the trip input has gone away. Clearing the flag does not release it.

A trip interrupt is produced as a one-clock pulse. Each event has an interrupt enable. When an enabled event flag rises while the interrupt flag is clear, the block pulses once and sets the interrupt flag. No further pulses follow until software clears the interrupt flag. If that clear happens while a one-shot or cycle-by-cycle flag is still set, the block fires again.

Top module: `pwm_trip_latch`

## Requirements
- R1: After a synchronous active-low reset, all flag bits, both trip outputs and the interrupt pulse are 0. A reset applied mid-run returns them all to 0.
- R2: The flag register has this layout:
  - bit 0: interrupt flag
  - bit 1: cycle-by-cycle trip
  - bit 2: one-shot trip
  - bit 3: compare A event 1 (`dc_evt[0]`)
  - bit 4: compare A event 2 (`dc_evt[1]`)
  - bit 5: compare B event 1 (`dc_evt[2]`)
  - bit 6: compare B event 2 (`dc_evt[3]`)
  - bits 15:7 always read 0, whatever is written.
- R3: An event flag sets on the clock edge that samples its enabled source high, and it stays set after the source falls. It clears only on a write with `wr_addr`=1 that carries a 1 in that bit. Bits written as 0 keep their value.
- R4: A write with `wr_addr`=0 targets the read-only flag register and changes nothing.
- R5: When a set event and a clear write hit the same bit on the same edge, the bit ends up set.
- R6: `cbc_trip` rises together with the cycle-by-cycle flag. It falls only after an edge on which `ctr_zero` is 1 and the enabled cycle-by-cycle source is 0, whether or not the flag has been cleared.
- R7: `ost_trip` equals the one-shot flag. It is unaffected by `ctr_zero`.
- R8: With `ost_en` or `cbc_en` low, the matching source sets nothing.
- R9: An event flag rising while the interrupt flag is clear does two things on that same edge, provided the event's enable bit is 1 (`irq_en[k]` maps to flag bit k+1): it sets the interrupt flag and it gives a `trip_irq` pulse exactly one clock wide. With the enable bit at 0, the flag still sets but no interrupt is raised.
- R10: While the interrupt flag stays set and is not being cleared, `trip_irq` stays 0, even when other event flags rise.
- R11: Clearing the interrupt flag while an interrupt-enabled cycle-by-cycle or one-shot flag remains set after that edge fires a new `trip_irq` pulse, and the interrupt flag sets again.
- R12: Clearing all flag bits while no source is asserted leaves the interrupt flag at 0 and produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ost_src | input | 1 | One-shot trip source |
| ost_en | input | 1 | One-shot source enable |
| cbc_src | input | 1 | Cycle-by-cycle trip source |
| cbc_en | input | 1 | Cycle-by-cycle source enable |
| dc_evt | input | 4 | Compare events: [0] A1, [1] A2, [2] B1, [3] B2 |
| ctr_zero | input | 1 | Time-base counter equals zero strobe |
| irq_en | input | 6 | Interrupt enable per event flag; bit k goes with flag bit k+1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = flag register (read-only), 1 = clear register |
| wr_data | input | 16 | Write data |
| flags | output | 16 | Flag register contents |
| cbc_trip | output | 1 | Cycle-by-cycle trip condition |
| ost_trip | output | 1 | One-shot trip condition |
| trip_irq | output | 1 | One-clock trip interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the sticky hold and set-over-clear priority of each flag cell;
- the hold and counter-zero release of the cycle-by-cycle condition;
- the silence of the interrupt while its flag is held;
- the re-fire when the interrupt flag is cleared under a live one-shot or cycle-by-cycle flag.

Other behaviour is shown only by the bench's scenarios:
- the bit positions of the register;
- that flag-register writes and zero writes are ignored;
- that masked enables raise flags without interrupts;
- that a full clear stops further interrupts.

// File: rtl/pwm_trip_pkg.sv
// Shared constants for the PWM trip latch: flag bit positions and sizes.
package pwm_trip_pkg;
    localparam int FLAG_W    = 16;  // width of the flag and clear registers
    localparam int NUM_DC    = 4;   // digital-compare events (A1, A2, B1, B2)
    localparam int BIT_INT   = 0;   // interrupt flag position
    localparam int BIT_CBC   = 1;   // cycle-by-cycle flag position
    localparam int BIT_OST   = 2;   // one-shot flag position
    localparam int BIT_DC0   = 3;   // first compare-event flag position
    localparam int EVT_CBC   = BIT_CBC - 1;  // index inside the event vector
    localparam int EVT_OST   = BIT_OST - 1;
endpackage

// File: rtl/trip_flag_cell.sv
// One sticky event flag. It sets when set_i is high and clears on clr_i.
// A set on the same edge as a clear wins. Assumes set_i is already gated
// by its source enable.
module trip_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic flag_nxt_o,
    output logic rise_o
);
    logic flag_q;

    // Next value: set has priority over a clear of the same bit.
    always_comb begin
        flag_nxt_o = set_i | (flag_q & ~clr_i);
    end

    // Holds the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_nxt_o;
    end

    assign flag_o = flag_q;
    assign rise_o = set_i & ~flag_q;

    // R3: a set flag without a clear stays set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    // R3: a clear with no competing set empties the flag
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    // R5: a set always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/cbc_trip_hold.sv
// Cycle-by-cycle trip condition. It is set by the enabled trip source and
// released only on a counter-zero strobe while the source is low. It is
// independent of the software-cleared flag.
module cbc_trip_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic ctr_zero_i,
    output logic cond_o
);
    logic cond_q;

    // Set by the trip, released at counter zero once the trip has gone.
    always_ff @(posedge clk) begin
        if (!rst_n)          cond_q <= 1'b0;
        else if (trip_i)     cond_q <= 1'b1;
        else if (ctr_zero_i) cond_q <= 1'b0;
    end

    assign cond_o = cond_q;

    // R6: the condition holds between counter-zero strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_q && !ctr_zero_i) |=> cond_q);
    // R6: an active trip input keeps or raises the condition
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> cond_q);
    // R6: counter zero with no trip releases it
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_zero_i && !trip_i) |=> !cond_q);
endmodule

// File: rtl/trip_irq_gate.sv
// Interrupt flag and one-clock pulse. It fires on an enabled flag rise
// while the interrupt flag is clear (or being cleared). It fires again
// when the interrupt flag is cleared while a re-fire-capable flag (per
// REFIRE_MASK) stays set. Inputs come from the flag cells of the same cycle.
module trip_irq_gate #(
    parameter int                 NUM_EVT     = 6,
    parameter logic [NUM_EVT-1:0] REFIRE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] rise_i,
    input  logic [NUM_EVT-1:0] flag_nxt_i,
    input  logic [NUM_EVT-1:0] en_i,
    input  logic               int_clr_i,
    output logic               int_flag_o,
    output logic               irq_o
);
    logic int_q;
    logic irq_q;
    logic gate_open;
    logic new_evt;
    logic refire;
    logic fire;

    // Decide whether an interrupt fires on this edge.
    always_comb begin
        gate_open = ~int_q | int_clr_i;
        new_evt   = |(rise_i & en_i);
        refire    = int_clr_i & (|(flag_nxt_i & en_i & REFIRE_MASK));
        fire      = gate_open & (new_evt | refire);
    end

    // Interrupt flag: a fire beats a clear; the pulse lasts one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            int_q <= fire | (int_q & ~int_clr_i);
            irq_q <= fire;
        end
    end

    assign int_flag_o = int_q;
    assign irq_o      = irq_q;

    // R10: no pulse while the interrupt flag is held
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (int_q && !int_clr_i) |=> !irq_q);
    // R9: every pulse comes with the interrupt flag set
    a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> int_q);
    // R9: an enabled rise on an idle gate fires
    a_r9_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_q && (|(rise_i & en_i))) |=> (irq_q && int_q));
    // R11: clearing the interrupt flag under a live trip flag re-fires
    a_r11_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr_i && (|(flag_nxt_i & en_i & REFIRE_MASK))) |=> (irq_q && int_q));
endmodule

// File: rtl/pwm_trip_latch.sv
// PWM trip fault latch: sticky event flags, a write-1-to-clear register,
// the two trip conditions and the trip interrupt. Assumes the sources are
// synchronous to clk and the enables are already decoded.
module pwm_trip_latch
    import pwm_trip_pkg::*;
#(
    parameter int REG_W  = FLAG_W,
    parameter int DC_CNT = NUM_DC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ost_src,
    input  logic                ost_en,
    input  logic                cbc_src,
    input  logic                cbc_en,
    input  logic [DC_CNT-1:0]   dc_evt,
    input  logic                ctr_zero,
    input  logic [DC_CNT+1:0]   irq_en,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    flags,
    output logic                cbc_trip,
    output logic                ost_trip,
    output logic                trip_irq
);
    localparam int NUM_EVT  = DC_CNT + 2;
    localparam int NUM_FLAG = NUM_EVT + 1;
    localparam logic [NUM_EVT-1:0] REFIRE_MASK =
        NUM_EVT'((1 << EVT_CBC) | (1 << EVT_OST));

    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] evt_nxt;
    logic [NUM_EVT-1:0] evt_rise;
    logic [NUM_FLAG-1:0] clr_vec;
    logic               int_q;
    logic               unused_wr_hi;

    // Gate the trip sources and gather the event set requests.
    always_comb begin
        evt_set                  = '0;
        evt_set[EVT_CBC]         = cbc_en & cbc_src;
        evt_set[EVT_OST]         = ost_en & ost_src;
        evt_set[NUM_EVT-1:2]     = dc_evt;
    end

    // Decode write-1-to-clear; writes to the flag register do nothing.
    always_comb begin
        clr_vec = (wr_en && wr_addr) ? wr_data[NUM_FLAG-1:0] : '0;
    end

    assign unused_wr_hi = ^wr_data[REG_W-1:NUM_FLAG];

    // One sticky cell per event flag.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        trip_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (evt_set[i]),
            .clr_i      (clr_vec[i+1]),
            .flag_o     (evt_q[i]),
            .flag_nxt_o (evt_nxt[i]),
            .rise_o     (evt_rise[i])
        );
    end

    cbc_trip_hold u_cbc (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_i     (evt_set[EVT_CBC]),
        .ctr_zero_i (ctr_zero),
        .cond_o     (cbc_trip)
    );

    trip_irq_gate #(
        .NUM_EVT     (NUM_EVT),
        .REFIRE_MASK (REFIRE_MASK)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (evt_rise),
        .flag_nxt_i (evt_nxt),
        .en_i       (irq_en),
        .int_clr_i  (clr_vec[BIT_INT]),
        .int_flag_o (int_q),
        .irq_o      (trip_irq)
    );

    // Assemble the register image; reserved bits read as zero.
    always_comb begin
        flags                 = '0;
        flags[BIT_INT]        = int_q;
        flags[NUM_FLAG-1:1]   = evt_q;
    end

    assign ost_trip = evt_q[EVT_OST];

    // R7: the counter-zero strobe never releases the one-shot condition
    a_r7_ost_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_trip && !clr_vec[BIT_OST]) |=> ost_trip);
    // R8: a disabled one-shot source cannot raise a fresh trip
    a_r8_ost_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ost_en && !ost_trip) |=> !ost_trip);
endmodule

// File: tb/pwm_trip_latch_bench.sv
`timescale 1ns/100ps
module pwm_trip_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ost_src = 0, ost_en = 1, cbc_src = 0, cbc_en = 1;
    logic [3:0]  dc_evt = '0;
    logic        ctr_zero = 0;
    logic [5:0]  irq_en = 6'h3F;
    logic        wr_en = 0, wr_addr = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] flags;
    logic        cbc_trip, ost_trip, trip_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    pwm_trip_latch u_pwm_trip_latch (
        .clk(clk), .rst_n(rst_n), .ost_src(ost_src), .ost_en(ost_en),
        .cbc_src(cbc_src), .cbc_en(cbc_en), .dc_evt(dc_evt),
        .ctr_zero(ctr_zero), .irq_en(irq_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags),
        .cbc_trip(cbc_trip), .ost_trip(ost_trip), .trip_irq(trip_irq)
    );

    // Vector: {tag[4], ost, cbc, dc[4], zero, we, wa, wdata[16],
    //          exp_flags[16], exp_cbc, exp_ost, exp_irq}
    localparam logic [47:0] VEC [25] = '{
        {4'd1,  2'b00, 4'b0000, 3'b000, 16'h0000, 16'h0000, 3'b000}, // R1 idle
        {4'd9,  2'b00, 4'b0001, 3'b000, 16'h0000, 16'h0009, 3'b001}, // R9 A1 rise
        {4'd9,  2'b00, 4'b0000, 3'b000, 16'h0000, 16'h0009, 3'b000}, // R9 one clock
        {4'd10, 2'b00, 4'b0100, 3'b000, 16'h0000, 16'h0029, 3'b000}, // R10 B1, no pulse
        {4'd3,  2'b00, 4'b0000, 3'b011, 16'h0028, 16'h0001, 3'b000}, // R3 clear A1,B1
        {4'd12, 2'b00, 4'b0000, 3'b011, 16'h0001, 16'h0000, 3'b000}, // R12 clear int
        {4'd6,  2'b01, 4'b0000, 3'b000, 16'h0000, 16'h0003, 3'b101}, // R6 cbc trip
        {4'd6,  2'b00, 4'b0000, 3'b000, 16'h0000, 16'h0003, 3'b100}, // R6 src gone
        {4'd6,  2'b00, 4'b0000, 3'b011, 16'h0002, 16'h0001, 3'b100}, // R6 flag cleared, cond held
        {4'd6,  2'b00, 4'b0000, 3'b100, 16'h0000, 16'h0001, 3'b000}, // R6 zero releases
        {4'd3,  2'b00, 4'b0000, 3'b011, 16'h0001, 16'h0000, 3'b000}, // R3 clear int
        {4'd9,  2'b01, 4'b0000, 3'b000, 16'h0000, 16'h0003, 3'b101}, // R9 cbc rise
        {4'd11, 2'b00, 4'b0000, 3'b011, 16'h0001, 16'h0003, 3'b101}, // R11 refire
        {4'd5,  2'b01, 4'b0000, 3'b011, 16'h0003, 16'h0003, 3'b101}, // R5 set beats clear
        {4'd6,  2'b01, 4'b0000, 3'b100, 16'h0000, 16'h0003, 3'b100}, // R6 zero under trip
        {4'd6,  2'b00, 4'b0000, 3'b011, 16'h0003, 16'h0000, 3'b100}, // R6 cond outlives flag
        {4'd6,  2'b00, 4'b0000, 3'b100, 16'h0000, 16'h0000, 3'b000}, // R6 released
        {4'd7,  2'b10, 4'b0000, 3'b000, 16'h0000, 16'h0005, 3'b011}, // R7 one-shot
        {4'd7,  2'b00, 4'b0000, 3'b100, 16'h0000, 16'h0005, 3'b010}, // R7 zero ignored
        {4'd4,  2'b00, 4'b0000, 3'b010, 16'hFFFF, 16'h0005, 3'b010}, // R4 flag reg write
        {4'd3,  2'b00, 4'b0000, 3'b011, 16'h0000, 16'h0005, 3'b010}, // R3 zero write
        {4'd12, 2'b00, 4'b0000, 3'b011, 16'hFFFF, 16'h0000, 3'b000}, // R12 clear all
        {4'd2,  2'b00, 4'b1010, 3'b000, 16'h0000, 16'h0051, 3'b001}, // R2 A2,B2 positions
        {4'd2,  2'b00, 4'b0000, 3'b011, 16'hFFFF, 16'h0000, 3'b000}, // R2 reserved zero
        {4'd12, 2'b00, 4'b0000, 3'b000, 16'h0000, 16'h0000, 3'b000}  // R12 stays quiet
    };

    task automatic check(input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input int tag, input logic [15:0] ef,
                             input logic ec, input logic eo, input logic ei);
        check(tag, "flags", 32'(flags), 32'(ef));
        check(tag, "cbc_trip", 32'(cbc_trip), 32'(ec));
        check(tag, "ost_trip", 32'(ost_trip), 32'(eo));
        check(tag, "trip_irq", 32'(trip_irq), 32'(ei));
    endtask

    // Drive inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic os, input logic cs, input logic [3:0] dc,
                        input logic z, input logic we, input logic wa,
                        input logic [15:0] wd);
        @(negedge clk);
        ost_src = os; cbc_src = cs; dc_evt = dc; ctr_zero = z;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_all(1, 16'h0000, 0, 0, 0);  // R1 reset state

        for (int i = 0; i < 25; i++) begin
            logic [47:0] v;
            v = VEC[i];
            step(v[43], v[42], v[41:38], v[37], v[36], v[35], v[34:19]);
            check_all(int'(v[47:44]), v[18:3], v[2], v[1], v[0]);
        end

        // R8: disabled sources set nothing
        ost_en = 0; cbc_en = 0;
        step(1, 1, 4'b0000, 0, 0, 0, 16'h0000);
        check_all(8, 16'h0000, 0, 0, 0);
        step(0, 0, 4'b0000, 0, 0, 0, 16'h0000);
        ost_en = 1; cbc_en = 1;

        // R9: masked enable sets the flag without an interrupt
        irq_en = 6'b111011;  // bit 2 masks A1 (flag bit 3)
        step(0, 0, 4'b0001, 0, 0, 0, 16'h0000);
        check_all(9, 16'h0008, 0, 0, 0);
        step(0, 0, 4'b0000, 0, 1, 1, 16'h0008);
        check_all(9, 16'h0000, 0, 0, 0);
        irq_en = 6'h3F;

        // R9: held event source gives only one pulse
        step(0, 0, 4'b0010, 0, 0, 0, 16'h0000);
        check_all(9, 16'h0011, 0, 0, 1);
        step(0, 0, 4'b0010, 0, 0, 0, 16'h0000);
        check_all(9, 16'h0011, 0, 0, 0);

        // R1: reset mid-run clears everything
        step(1, 1, 4'b0000, 0, 0, 0, 16'h0000);
        @(negedge clk);
        ost_src = 0; cbc_src = 0; dc_evt = '0; rst_n = 0;
        @(posedge clk); #1;
        check_all(1, 16'h0000, 0, 0, 0);
        @(negedge clk) rst_n = 1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule